// File: doc/BRIEF.md
# Logical Shifter with Selectable Count Handling

This block shifts a 64-bit or 32-bit operand left or right by a count, filling vacated positions with zeros. A two-bit mode input selects how the count is treated. In the wrap mode, only as many low count bits as the lane width needs are used, so the count wraps modulo the width. In the byte mode, the low eight count bits are used. In the linear mode, the whole count is used. In the byte and linear modes, any count that reaches the lane width clears the result. This lets one datapath follow the shift-count conventions of several processor families.

The block compares the count against the lane width in parallel with a logarithmic multiplexer shifter. When the count is out of range, that comparison forces the result to zero. In 32-bit lanes, the upper half of the operand is ignored and the upper half of the result is held at zero. By default the result is registered, which gives one clock of latency. A parameter can remove the register.

Top module: `shf_unit`

## Requirements
- R1: While `rst_ni` is low, `result_o` is zero, and it stays zero until the first clock edge after release.
- R2: With `dir_i` = 0 the operand is shifted toward the most significant bit and zeros enter at bit 0.
- R3: With `dir_i` = 1 the operand is shifted toward bit 0 and zeros enter at the top of the lane. The count rules of the selected mode apply unchanged.
- R4: Mode `mode_i` = 2'b00 in a 32-bit lane (`wide_i` = 0) shifts by `count_i[4:0]` only, so a count of 32 gives the operand back unchanged.
- R5: Mode 2'b00 in a 64-bit lane (`wide_i` = 1) shifts by `count_i[5:0]` only. A count of 64 acts as 0 and a count of 70 acts as 6.
- R6: Mode 2'b01 shifts by `count_i[7:0]`. When that value is at least the lane width (32 or 64), the result is zero. A count of 256 wraps to a shift of 0.
- R7: Modes 2'b10 and 2'b11 use all of `count_i`. Any count at or above the lane width, including 256 and above, gives zero.
- R8: With `wide_i` = 0, only `operand_i[31:0]` takes part in the shift, and `result_o[63:32]` is zero.
- R9: With the default `REG_OUT` = 1, `result_o` reflects the inputs sampled at the preceding rising edge of `clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Asynchronous active-low reset |
| operand_i | input | 64 | Value to be shifted |
| count_i | input | 16 | Shift count before mode handling |
| dir_i | input | 1 | 0 shifts left, 1 shifts right |
| wide_i | input | 1 | 1 selects a 64-bit lane, 0 a 32-bit lane |
| mode_i | input | 2 | Count handling: 00 wrap, 01 byte, 10/11 linear |
| result_o | output | 64 | Shifted result |

## Verification
The bench drives counts exactly at the lane width, at width plus small offsets, and at 255, 256 and beyond in each mode. Two faults show up here. A design that wraps where it should clear returns the operand instead of zero. A design that clears where it should wrap returns zero instead of the operand. Right shifts in a 32-bit lane use operands with ones in the upper half, so a design that lets those bits leak into the lane, or that fails to clear `result_o[63:32]`, gives visibly wrong values. Dedicated cases check the reset value and the one-cycle latency, which catch a missing or extra register stage.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [1:0] {
        CNT_WRAP     = 2'b00,
        CNT_BYTE     = 2'b01,
        CNT_LINEAR   = 2'b10,
        CNT_LINEAR_B = 2'b11
    } cnt_mode_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shf_dir_e;

    localparam int unsigned BYTE_CNT_W = 8;

endpackage

// File: rtl/shf_count_eval.sv
module shf_count_eval
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned CNT_W  = 16,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             wide_i,
    input  cnt_mode_e        mode_i,
    output logic [AMT_W-1:0] amt_o,
    output logic             oversize_o
);

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam logic [CNT_W-1:0] MASK_WIDE   = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] MASK_NARROW = CNT_W'(HALF_W - 1);
    localparam logic [CNT_W:0]   LANE_WIDE   = (CNT_W+1)'(DATA_W);
    localparam logic [CNT_W:0]   LANE_NARROW = (CNT_W+1)'(HALF_W);

    logic [CNT_W-1:0] eff;
    logic [CNT_W:0]   lane_w;

    always_comb begin
        lane_w = wide_i ? LANE_WIDE : LANE_NARROW;
        unique case (mode_i)
            CNT_WRAP: eff = cnt_i & (wide_i ? MASK_WIDE : MASK_NARROW);
            CNT_BYTE: eff = CNT_W'(cnt_i[BYTE_CNT_W-1:0]);
            default:  eff = cnt_i;
        endcase
        oversize_o = ({1'b0, eff} >= lane_w);
        amt_o      = eff[AMT_W-1:0];
    end

endmodule

// File: rtl/shf_barrel.sv
module shf_barrel #(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned AMT_W = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic              right_i,
    output logic [DATA_W-1:0] data_o
);

    logic [DATA_W-1:0] data_rev;
    logic [DATA_W-1:0] stage [AMT_W+1];
    logic [DATA_W-1:0] stage_rev;

    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign data_rev[b]  = data_i[DATA_W-1-b];
        assign stage_rev[b] = stage[AMT_W][DATA_W-1-b];
    end

    assign stage[0] = right_i ? data_rev : data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        assign stage[s+1] = amt_i[s] ? (stage[s] << (2 ** s)) : stage[s];
    end

    assign data_o = right_i ? stage_rev : stage[AMT_W];

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned CNT_W   = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] operand_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              dir_i,
    input  logic              wide_i,
    input  logic [1:0]        mode_i,
    output logic [DATA_W-1:0] result_o
);

    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned AMT_W  = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
    } shf_state_t;

    shf_state_t        st_d;
    logic [DATA_W-1:0] lane_data;
    logic [DATA_W-1:0] shifted;
    logic [AMT_W-1:0]  amt;
    logic              oversize;

    assign lane_data = wide_i ? operand_i : {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};

    shf_count_eval #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_cnt (
        .cnt_i     (count_i),
        .wide_i    (wide_i),
        .mode_i    (cnt_mode_e'(mode_i)),
        .amt_o     (amt),
        .oversize_o(oversize)
    );

    shf_barrel #(
        .DATA_W(DATA_W)
    ) u_barrel (
        .data_i (lane_data),
        .amt_i  (amt),
        .right_i(dir_i == DIR_RIGHT),
        .data_o (shifted)
    );

    always_comb begin
        st_d = '0;
        if (!oversize) begin
            st_d.res = wide_i ? shifted : {{HALF_W{1'b0}}, shifted[HALF_W-1:0]};
        end
    end

    if (REG_OUT) begin : g_reg
        shf_state_t st_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) st_q <= '0;
            else         st_q <= st_d;
        end
        assign result_o = st_q.res;
    end else begin : g_comb
        assign result_o = st_d.res;
    end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned CNT_W   = 16,
    parameter bit          REG_OUT = 1'b1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [DATA_W-1:0] operand_i,
    input logic [CNT_W-1:0]  count_i,
    input logic              dir_i,
    input logic              wide_i,
    input logic [1:0]        mode_i,
    input logic [DATA_W-1:0] result_o
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] op_c;
    logic [CNT_W-1:0]  cnt_c;
    logic              wide_c;
    logic [1:0]        mode_c;
    logic              v_c;

    if (REG_OUT) begin : g_seen
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                op_c <= '0; cnt_c <= '0; wide_c <= 1'b0; mode_c <= '0; v_c <= 1'b0;
            end else begin
                op_c <= operand_i; cnt_c <= count_i; wide_c <= wide_i;
                mode_c <= mode_i; v_c <= 1'b1;
            end
        end
    end else begin : g_now
        assign op_c = operand_i; assign cnt_c = count_i; assign wide_c = wide_i;
        assign mode_c = mode_i; assign v_c = 1'b1;
    end

    logic [CNT_W:0]    lane_w_c;
    logic [CNT_W-1:0]  lane_mask_c;
    logic [DATA_W-1:0] lane_op_c;
    logic              unused_dir;

    assign lane_w_c    = wide_c ? (CNT_W+1)'(DATA_W) : (CNT_W+1)'(HALF_W);
    assign lane_mask_c = wide_c ? CNT_W'(DATA_W - 1) : CNT_W'(HALF_W - 1);
    assign lane_op_c   = wide_c ? op_c : {{HALF_W{1'b0}}, op_c[HALF_W-1:0]};
    assign unused_dir  = dir_i;

    AST_NARROW_HI_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_c && !wide_c |-> result_o[DATA_W-1:HALF_W] == '0); // R8

    AST_LINEAR_BIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_c && mode_c[1] && ({1'b0, cnt_c} >= lane_w_c) |-> result_o == '0); // R7

    AST_BYTE_BIG_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_c && mode_c == 2'b01 && ((CNT_W+1)'(cnt_c[7:0]) >= lane_w_c) |-> result_o == '0); // R6

    AST_WRAP_IDENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_c && mode_c == 2'b00 && ((cnt_c & lane_mask_c) == '0) |-> result_o == lane_op_c); // R4 R5

    AST_ZERO_IN_ZERO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        v_c && op_c == '0 |-> result_o == '0); // R2 R3

    if (REG_OUT) begin : g_rst_chk
        AST_RESET_CLEAR: assert property (@(posedge clk_i)
            !rst_ni |=> result_o == '0); // R1
    end

endmodule

bind shf_unit shf_unit_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .REG_OUT(REG_OUT)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .operand_i(operand_i),
    .count_i  (count_i),
    .dir_i    (dir_i),
    .wide_i   (wide_i),
    .mode_i   (mode_i),
    .result_o (result_o)
);

// File: tb/shf_unit_tb_top.sv
module shf_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 20;

    typedef struct packed {
        logic [63:0] op;
        logic [15:0] cnt;
        logic        dir;
        logic        wide;
        logic [1:0]  mode;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [N_VEC] = '{
        {64'h1, 16'd1, 1'b0, 1'b1, 2'd0, 64'h2, 4'd2},                                   // R2
        {64'h8000_0000_0000_0000, 16'd4, 1'b1, 1'b1, 2'd2, 64'h0800_0000_0000_0000, 4'd3}, // R3
        {64'h1, 16'd32, 1'b0, 1'b0, 2'd0, 64'h1, 4'd4},                                  // R4
        {64'h1, 16'd33, 1'b0, 1'b0, 2'd0, 64'h2, 4'd4},                                  // R4
        {64'h1, 16'd64, 1'b0, 1'b1, 2'd0, 64'h1, 4'd5},                                  // R5
        {64'h1, 16'd70, 1'b0, 1'b1, 2'd0, 64'h40, 4'd5},                                 // R5
        {64'h1, 16'd40, 1'b0, 1'b0, 2'd1, 64'h0, 4'd6},                                  // R6
        {64'h1, 16'd255, 1'b0, 1'b1, 2'd1, 64'h0, 4'd6},                                 // R6
        {64'h1, 16'd256, 1'b0, 1'b1, 2'd1, 64'h1, 4'd6},                                 // R6
        {64'h1, 16'd257, 1'b0, 1'b0, 2'd1, 64'h2, 4'd6},                                 // R6
        {64'h1, 16'd256, 1'b0, 1'b1, 2'd2, 64'h0, 4'd7},                                 // R7
        {64'h1, 16'd63, 1'b0, 1'b1, 2'd2, 64'h8000_0000_0000_0000, 4'd7},                // R7
        {64'h1, 16'd64, 1'b0, 1'b1, 2'd3, 64'h0, 4'd7},                                  // R7
        {64'hFFFF_FFFF_FFFF_FFFF, 16'd4, 1'b0, 1'b0, 2'd2, 64'hFFFF_FFF0, 4'd8},         // R8
        {64'hFFFF_FFFF_FFFF_FFFF, 16'd4, 1'b1, 1'b0, 2'd2, 64'h0FFF_FFFF, 4'd8},         // R8
        {64'h0000_0001_0000_0000, 16'd1, 1'b1, 1'b0, 2'd2, 64'h0, 4'd8},                 // R8
        {64'h8000_0000, 16'd36, 1'b1, 1'b0, 2'd0, 64'h0800_0000, 4'd4},                  // R4 with R3
        {64'h8000_0000_0000_0000, 16'd300, 1'b1, 1'b1, 2'd1, 64'h8_0000, 4'd6},          // R6 with R3
        {64'hF0, 16'hFFFF, 1'b1, 1'b1, 2'd0, 64'h0, 4'd5},                               // R5
        {64'h1234_5678_9ABC_DEF0, 16'd8, 1'b0, 1'b1, 2'd2, 64'h3456_789A_BCDE_F000, 4'd2} // R2
    };

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [63:0] operand_i = '0;
    logic [15:0] count_i = '0;
    logic        dir_i = 1'b0;
    logic        wide_i = 1'b1;
    logic [1:0]  mode_i = '0;
    logic [63:0] result_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    shf_unit dut_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .operand_i(operand_i),
        .count_i  (count_i),
        .dir_i    (dir_i),
        .wide_i   (wide_i),
        .mode_i   (mode_i),
        .result_o (result_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] op, input logic [15:0] cnt,
                         input logic dir, input logic wide, input logic [1:0] mode);
        operand_i = op; count_i = cnt; dir_i = dir; wide_i = wide; mode_i = mode;
    endtask

    initial begin
        repeat (3) @(negedge clk_i);
        check("R1 reset value", result_o, 64'h0);
        rst_ni = 1'b1;
        check("R1 held until first edge", result_o, 64'h0);

        for (int i = 0; i < N_VEC; i++) begin
            @(negedge clk_i);
            drive(VECS[i].op, VECS[i].cnt, VECS[i].dir, VECS[i].wide, VECS[i].mode);
            @(negedge clk_i);
            check($sformatf("R%0d vector %0d", VECS[i].req, i), result_o, VECS[i].exp);
        end

        // R9: output changes only after the next rising edge
        @(negedge clk_i);
        drive(64'h1, 16'd5, 1'b0, 1'b1, 2'd2);
        @(negedge clk_i);
        check("R9 registered", result_o, 64'h20);
        drive(64'h1, 16'd6, 1'b0, 1'b1, 2'd2);
        #1;
        check("R9 holds before edge", result_o, 64'h20);
        @(negedge clk_i);
        check("R9 updates after edge", result_o, 64'h40);

        // R1: asynchronous reset mid-run
        rst_ni = 1'b0;
        #1;
        check("R1 async clear", result_o, 64'h0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        check("R1 after release", result_o, 64'h0);
        @(negedge clk_i);
        check("R2 after reset", result_o, 64'h40);

        // R7: linear count far beyond width in a narrow lane, right shift
        drive(64'hFFFF_FFFF, 16'h8000, 1'b1, 1'b0, 2'd2);
        @(negedge clk_i);
        check("R7 huge count", result_o, 64'h0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule